// File: doc/BRIEF.md
# Transmit Flush and Wakeup Controller

This block decides when bytes waiting in a transmit buffer are handed to the host. Each time the host asks for data with a bulk-IN request, the block answers with a release command and a byte count. It sends a full packet whenever one is available. It holds back a short packet until either a programmable millisecond latency timer has run out or an external send-immediate strobe has been seen.

The same active-low strobe pin has a second use. While the bus is suspended and remote wakeup is enabled, a falling edge on the pin raises a one-cycle resume request instead of a send-immediate. While the bus is suspended and remote wakeup is disabled, the strobe does nothing. The latency limit resets to 16 ms and can be reloaded at any time with an 8-bit value in millisecond steps.

Top module: `txf_flush_ctrl`

## Requirements
- R1: A partial packet (1 to 63 bytes) becomes releasable only after the programmed number of `ms_tick` pulses has been counted since the latency timer last restarted. A request made before that count is reached releases nothing.
- R2: The latency limit resets to 16 ticks. A cycle with `tmo_wr` high loads `tmo_val` as the new limit, and limits from 1 to 255 are honoured.
- R3: A loaded limit of 0 behaves as a limit of 1 tick.
- R4: On a request with `buf_count` of 64 or more, the block releases a full packet: `rel_len` = 64, with no wait for the timer or a strobe. `rel_len` is always the number of bytes released, in the range 1 to 64.
- R5: A falling edge on `si_wu_n` while `suspended` is low arms send-immediate. Each later request then releases what is held, as full packets first and then the remainder. Send-immediate stays armed until a release whose length equals `buf_count`.
- R6: A falling edge on `si_wu_n` while `suspended` and `rwu_en` are both high gives a one-cycle `resume_req` pulse on the third rising clock edge after the pin falls. It does not arm send-immediate.
- R7: A falling edge on `si_wu_n` while `suspended` is high and `rwu_en` is low has no effect: there is no resume pulse and send-immediate is not armed.
- R8: The latency timer restarts on every release and whenever `buf_count` goes from zero to non-zero. Ticks are not counted while the buffer is empty.
- R9: `rel_valid` is high for exactly the cycle after a `bulk_in_req` cycle that qualifies. A request with an empty buffer, or with a partial packet that is not yet eligible, releases nothing.
- R10: After reset, `rel_valid` and `resume_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| buf_count | input | CNT_W (9) | Bytes waiting in the transmit buffer |
| bulk_in_req | input | 1 | One-cycle pulse: host asks for data |
| ms_tick | input | 1 | One-cycle pulse each millisecond |
| tmo_wr | input | 1 | Load `tmo_val` as the latency limit |
| tmo_val | input | 8 | Latency limit in milliseconds |
| suspended | input | 1 | Bus is in suspend |
| rwu_en | input | 1 | Remote wakeup allowed |
| si_wu_n | input | 1 | Asynchronous send-immediate / wakeup strobe, active low |
| rel_valid | output | 1 | Release command strobe |
| rel_len | output | 7 | Bytes to release, 1 to 64 |
| resume_req | output | 1 | One-cycle resume request |

## Verification
A release is due one cycle after its request: the bench raises `bulk_in_req` at a falling clock edge, and the monitor checks `rel_valid` and `rel_len` at the next falling edge. A resume pulse is due on the third rising edge after the pin falls, because the pin passes through two synchroniser flops and an edge flop first. The bench holds the pin low for four cycles and expects the pulse inside that window. Each expected result is queued before its stimulus. Any output that arrives with an empty queue is reported. After every step the queue must be empty, so a missing or extra release is caught.

// File: rtl/txf_pkg.sv
// Shared constants and helpers for the transmit flush controller.
// Assumes an 8-bit millisecond latency field.
package txf_pkg;
    localparam int TMO_W = 8;

    // Clamp a latency setting: a value of zero acts as one tick (R3)
    function automatic logic [TMO_W-1:0] eff_timeout(input logic [TMO_W-1:0] v);
        return (v == '0) ? TMO_W'(1) : v;
    endfunction
endpackage

// File: rtl/txf_strobe_sync.sv
// Brings the asynchronous active-low strobe into the clock domain and
// flags a one-cycle pulse on each falling edge.
// Assumes the idle level of the pin is high.
module txf_strobe_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic fall
);
    logic s1, s2, s3;

    // Two-flop synchroniser plus one delayed copy for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
            s3 <= 1'b1;
        end else begin
            s1 <= pin_n;
            s2 <= s1;
            s3 <= s2;
        end
    end

    // Falling edge of the synchronised level
    always_comb fall = s3 & ~s2;
endmodule

// File: rtl/txf_latency_timer.sv
// Counts millisecond ticks while the buffer holds data and raises
// 'expired' when the limit is reached. Restarts on a release and when
// the buffer turns non-empty; held clear while the buffer is empty.
// Assumes the limit given is already clamped to 1..255.
module txf_latency_timer
    import txf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ms_tick,
    input  logic             buf_nonempty,
    input  logic             rel_take,
    input  logic [TMO_W-1:0] limit,
    output logic             expired
);
    logic [TMO_W-1:0] cnt;
    logic             ne_q;
    logic [TMO_W:0]   cnt_nx;

    // Next tick count, one bit wider so the compare cannot wrap
    always_comb cnt_nx = {1'b0, cnt} + 1'b1;

    // Tick counter with restart and expiry flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            expired <= 1'b0;
            ne_q    <= 1'b0;
        end else begin
            ne_q <= buf_nonempty;
            if (!buf_nonempty || rel_take || !ne_q) begin
                cnt     <= '0;
                expired <= 1'b0;
            end else if (ms_tick && !expired) begin
                cnt <= cnt_nx[TMO_W-1:0];
                if (cnt_nx >= {1'b0, limit})
                    expired <= 1'b1;
            end
        end
    end

    AST_EXPIRE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(expired) |-> $past(ms_tick));                       // R1
    AST_EMPTY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !buf_nonempty |=> !expired);                              // R8
endmodule

// File: rtl/txf_release_sel.sv
// Chooses what to release on a bulk-IN request: a full packet when one
// is held, else the remainder if the timer expired or send-immediate is
// armed. Registers the command; reports take/drain combinationally.
// Assumes buf_count does not change in the request cycle.
module txf_release_sel #(
    parameter int CNT_W = 9,
    parameter int PKT   = 64,
    parameter int LEN_W = $clog2(PKT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] buf_count,
    input  logic             bulk_in_req,
    input  logic             expired,
    input  logic             si_armed,
    output logic             take,
    output logic             drain,
    output logic             rel_valid,
    output logic [LEN_W-1:0] rel_len
);
    logic             full;
    logic             part_ok;
    logic [LEN_W-1:0] len_nx;

    // Release decision for this cycle
    always_comb begin
        full    = buf_count >= CNT_W'(PKT);
        part_ok = (buf_count != '0) && (expired || si_armed);
        take    = bulk_in_req && (full || part_ok);
        drain   = take && (buf_count <= CNT_W'(PKT));
        len_nx  = full ? LEN_W'(PKT) : buf_count[LEN_W-1:0];
    end

    // Registered release command
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rel_valid <= 1'b0;
            rel_len   <= '0;
        end else begin
            rel_valid <= take;
            rel_len   <= take ? len_nx : '0;
        end
    end

    AST_REL_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rel_valid |-> $past(bulk_in_req));                        // R9
    AST_REL_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        rel_valid |-> (rel_len != '0 && rel_len <= LEN_W'(PKT))); // R4
    AST_REL_WITHIN_BUF: assert property (@(posedge clk) disable iff (!rst_n)
        rel_valid |-> (CNT_W'(rel_len) <= $past(buf_count)));     // R9
endmodule

// File: rtl/txf_flush_ctrl.sv
// Top of the transmit flush and wakeup controller. Holds the latency
// limit, the send-immediate flag and the resume pulse; the timer, the
// strobe synchroniser and the release selector are submodules.
// Assumes bulk_in_req and ms_tick are single-cycle pulses.
module txf_flush_ctrl
    import txf_pkg::*;
#(
    parameter int CNT_W    = 9,
    parameter int PKT      = 64,
    parameter int DEF_TMO  = 16,
    localparam int LEN_W   = $clog2(PKT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] buf_count,
    input  logic             bulk_in_req,
    input  logic             ms_tick,
    input  logic             tmo_wr,
    input  logic [TMO_W-1:0] tmo_val,
    input  logic             suspended,
    input  logic             rwu_en,
    input  logic             si_wu_n,
    output logic             rel_valid,
    output logic [LEN_W-1:0] rel_len,
    output logic             resume_req
);
    logic [TMO_W-1:0] tmo_q;
    logic             si_armed;
    logic             fall, expired, take, drain;

    // Latency limit register, default after reset
    always_ff @(posedge clk) begin
        if (!rst_n)      tmo_q <= TMO_W'(DEF_TMO);
        else if (tmo_wr) tmo_q <= tmo_val;
    end

    // Send-immediate flag: armed by a strobe while awake, cleared on drain
    always_ff @(posedge clk) begin
        if (!rst_n)                   si_armed <= 1'b0;
        else if (fall && !suspended)  si_armed <= 1'b1;
        else if (drain)               si_armed <= 1'b0;
    end

    // Resume pulse: strobe while suspended with wakeup allowed
    always_ff @(posedge clk) begin
        if (!rst_n) resume_req <= 1'b0;
        else        resume_req <= fall && suspended && rwu_en;
    end

    txf_strobe_sync u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_n (si_wu_n),
        .fall  (fall)
    );

    txf_latency_timer u_tmr (
        .clk          (clk),
        .rst_n        (rst_n),
        .ms_tick      (ms_tick),
        .buf_nonempty (buf_count != '0),
        .rel_take     (take),
        .limit        (eff_timeout(tmo_q)),
        .expired      (expired)
    );

    txf_release_sel #(.CNT_W(CNT_W), .PKT(PKT), .LEN_W(LEN_W)) u_sel (
        .clk         (clk),
        .rst_n       (rst_n),
        .buf_count   (buf_count),
        .bulk_in_req (bulk_in_req),
        .expired     (expired),
        .si_armed    (si_armed),
        .take        (take),
        .drain       (drain),
        .rel_valid   (rel_valid),
        .rel_len     (rel_len)
    );

    AST_RESUME_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        resume_req |-> ($past(suspended) && $past(rwu_en)));      // R6
    AST_RESUME_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        resume_req |=> !resume_req);                              // R6
    AST_SI_NOT_WHILE_SUSP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(si_armed) |-> !$past(suspended));                   // R7
endmodule

// File: tb/tb_txf_flush_ctrl.sv
module tb_txf_flush_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [8:0] buf_count = '0;
    logic       bulk_in_req = 1'b0, ms_tick = 1'b0, tmo_wr = 1'b0;
    logic [7:0] tmo_val = '0;
    logic       suspended = 1'b0, rwu_en = 1'b0, si_wu_n = 1'b1;
    logic       rel_valid, resume_req;
    logic [6:0] rel_len;

    int checks = 0, errors = 0, cycles = 0;
    int exp_q[$];          // expected outputs: length, or -1 for resume
    string cur_tag = "R10";
    bit done = 1'b0;

    always #5 clk = ~clk;

    txf_flush_ctrl dut (.*);

    // Monitor: pop and compare each produced output
    always @(negedge clk) begin
        if (rst_n && (rel_valid || resume_req)) begin
            int got;
            got = rel_valid ? int'(rel_len) : -1;
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL %s: unexpected output %0d, expected none", cur_tag, got);
            end else begin
                int e;
                e = exp_q.pop_front();
                if (e != got) begin
                    errors++;
                    $display("FAIL %s: output %0d, expected %0d", cur_tag, got, e);
                end
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            errors++;
            $display("FAIL watchdog: %0d cycles, expected finish", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic sb_done(input string tag);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL %s: %0d outputs missing, expected 0", tag, exp_q.size());
            exp_q.delete();
        end
    endtask

    task automatic req(input string tag, input int exp_len);
        cur_tag = tag;
        if (exp_len >= 0) exp_q.push_back(exp_len);
        @(negedge clk) bulk_in_req = 1'b1;
        @(negedge clk) bulk_in_req = 1'b0;
        @(negedge clk);
        sb_done(tag);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) ms_tick = 1'b1;
            @(negedge clk) ms_tick = 1'b0;
        end
    endtask

    task automatic set_count(input int v);
        @(negedge clk) buf_count = 9'(v);
        @(negedge clk);
    endtask

    task automatic set_tmo(input int v);
        @(negedge clk) begin tmo_wr = 1'b1; tmo_val = 8'(v); end
        @(negedge clk) tmo_wr = 1'b0;
    endtask

    task automatic strobe(input string tag, input bit exp_resume);
        cur_tag = tag;
        if (exp_resume) exp_q.push_back(-1);
        @(negedge clk) si_wu_n = 1'b0;
        repeat (4) @(negedge clk);
        si_wu_n = 1'b1;
        repeat (4) @(negedge clk);
        sb_done(tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (rel_valid !== 1'b0 || resume_req !== 1'b0) begin
            errors++;
            $display("FAIL R10: rel_valid=%b resume_req=%b, expected 0 0", rel_valid, resume_req);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R4 full packet released at once; R1 partial held back
        set_count(100);
        req("R4", 64);
        set_count(36);
        req("R1", -1);
        // R2 default limit 16: 15 ticks not enough, 16th is
        ticks(15);
        req("R2", -1);
        ticks(1);
        req("R2", 36);
        set_count(0);
        req("R9", -1);

        // R2 programmed limit 3
        set_tmo(3);
        set_count(10);
        ticks(2);
        req("R1", -1);
        ticks(1);
        req("R1", 10);
        set_count(0);

        // R3 zero limit acts as 1
        set_tmo(0);
        set_count(5);
        req("R3", -1);
        ticks(1);
        req("R3", 5);
        set_count(0);

        // R5 send-immediate releases remainder, then clears
        set_tmo(255);
        set_count(7);
        strobe("R5", 1'b0);
        req("R5", 7);
        set_count(0);
        set_count(3);
        req("R5", -1);
        set_count(0);
        set_count(90);
        strobe("R5", 1'b0);
        req("R5", 64);
        set_count(26);
        req("R5", 26);
        set_count(0);

        // R6 resume while suspended with wakeup allowed; no send-immediate
        set_count(4);
        suspended = 1'b1; rwu_en = 1'b1;
        strobe("R6", 1'b1);
        suspended = 1'b0;
        req("R6", -1);
        // R7 suspended without wakeup: no effect
        suspended = 1'b1; rwu_en = 1'b0;
        strobe("R7", 1'b0);
        suspended = 1'b0;
        req("R7", -1);
        set_count(0);

        // R8 restart on release
        set_tmo(3);
        set_count(100);
        ticks(2);
        req("R8", 64);
        set_count(36);
        ticks(2);
        req("R8", -1);
        ticks(1);
        req("R8", 36);
        set_count(0);
        // R8 ticks while empty ignored, restart on empty to non-empty
        ticks(5);
        set_count(8);
        ticks(2);
        req("R8", -1);
        ticks(1);
        req("R8", 8);
        set_count(0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule